// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of scatter-gather segments into a table of DMA descriptors held in a local memory. Each segment arrives as a 32-bit start address and a 32-bit byte length. The block cuts every segment into pieces that never cross a 64 KB address boundary. For each piece it writes a descriptor of two 32-bit words into the table: first the address word, then the length word. A consuming DMA engine then walks the table.

Two options are chosen when a build starts. The first is a workaround for controllers that read a zero 16-bit length field as zero bytes instead of 64 KB. With it enabled, a full 64 KB piece becomes two 32 KB descriptors. The second is an alternative length encoding for one controller family. In that encoding the length word carries the byte count divided by four, minus one, in its upper half, and no end marker is written.

When the build finishes, the block pulses `done` and presents the entry count. A count of zero means the request has to fall back to programmed I/O. This happens in two cases: the table would overflow, which also raises `overflow`, or the segments held no bytes.

Top module: `sgt_builder`

## Requirements
- R1: After reset, `segReady`, `done` and `wrEn` are low, and `entryCount` and `overflow` are zero.
- R2: Each piece is min(0x10000 − (address mod 0x10000), remaining bytes) long. The address advances and the remaining count drops by the size of each piece, so no descriptor crosses a 64 KB boundary.
- R3: Descriptor k uses table word 2k for its address and word 2k+1 for its length. Each word is 32 bits wide, little-endian, with byte 0 in bits 7:0.
- R4: In normal mode (`altLenMode`=0), bits 15:0 of a length word hold the piece size modulo 65536, and bits 30:16 are zero.
- R5: In normal mode with `splitFullChunk`=1, a 64 KB piece is written as two descriptors of length 0x8000: the first at the piece address, the second at that address plus 0x8000. With `splitFullChunk`=0 it is written as one descriptor with length field 0x0000.
- R6: In the alternative mode (`altLenMode`=1), bits 31:16 of a length word hold (size/4) − 1 and bits 15:0 are zero. `splitFullChunk` has no effect in this mode. Buffers must be 4-byte aligned.
- R7: In normal mode, bit 31 is set in the length word of the last descriptor only. In the alternative mode no word carries that bit.
- R8: If the next piece needs more entries than `MAX_ENTRIES` allows, the build stops and `overflow` rises. This counts both halves of a 64 KB split. `entryCount` then reports 0. Any remaining segments up to the one flagged `segLast` are still accepted and discarded.
- R9: A zero-length segment produces no descriptor. A build whose segments hold no bytes ends with `entryCount`=0 and `overflow`=0.
- R10: `done` is high for exactly one cycle. `entryCount` and `overflow` keep their values until the next accepted start.
- R11: `start` is ignored while a build is in progress. The mode inputs are sampled only with an accepted start.
- R12: A request that needs exactly `MAX_ENTRIES` descriptors succeeds and reports that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a build when the block is idle |
| altLenMode | input | 1 | Selects the alternative length encoding (sampled at start) |
| splitFullChunk | input | 1 | Enables splitting of 64 KB pieces (sampled at start) |
| segValid | input | 1 | Segment on the stream is valid |
| segReady | output | 1 | Block accepts a segment this cycle |
| segAddr | input | 32 | Segment start address |
| segLen | input | 32 | Segment length in bytes |
| segLast | input | 1 | Marks the final segment of the request |
| wrEn | output | 1 | Table write strobe |
| wrIdx | output | $clog2(2*MAX_ENTRIES) | Table word index |
| wrData | output | 32 | Table word |
| done | output | 1 | One-cycle end-of-build pulse |
| entryCount | output | $clog2(MAX_ENTRIES+1) | Descriptors built; 0 means fall back |
| overflow | output | 1 | Table limit was exceeded |

## Verification
The bench targets the places where the chunk arithmetic can slip by one piece, using segments just below a 64 KB boundary, exactly on one, and spanning several. A wrong boundary calculation would give the wrong count or a wrong second address. The 64 KB split is tested right at the table limit, where a checker that counts only one of the two halves would accept a table one entry too long. A build that fits exactly is tested too, where an off-by-one limit would report a false overflow. Further cases cover end-marker placement across segments, zero-length segments, draining after an overflow, and a start pulse issued mid-build. Each of these shows up as a misplaced or missing bit 31, a hung stream, or a silent change of mode.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET,
    ST_ADDR,
    ST_LEN,
    ST_DRAIN,
    ST_FIN,
    ST_DONE
  } sgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic init;
    logic loadSeg;
    logic wrAddrWord;
    logic wrLenWord;
    logic wrMark;
    logic setOvf;
  } sgtCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic segZero;
    logic segLastReg;
    logic pieceEnd;
    logic wouldOvf;
    logic haveEntries;
    logic altMode;
    logic ovf;
  } sgtStat_t;

  localparam logic [31:0] END_FLAG    = 32'h8000_0000;
  localparam logic [31:0] FULL_CHUNK  = 32'h0001_0000;
  localparam logic [31:0] HALF_CHUNK  = 32'h0000_8000;

endpackage

// File: rtl/sgt_ctrl.sv
module sgt_ctrl
  import sgt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     segValid,
  input  logic     segLast,
  input  sgtStat_t stat,
  output sgtCmd_t  cmd,
  output logic     segReady,
  output logic     done
);

  sgtState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    cmd       = '0;
    nextState = state;
    segReady  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          cmd.init  = 1'b1;
          nextState = ST_GET;
        end
      end
      ST_GET: begin
        segReady = 1'b1;
        if (segValid) begin
          cmd.loadSeg = 1'b1;
          if (stat.segZero) nextState = segLast ? ST_FIN : ST_GET;
          else              nextState = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (stat.wouldOvf) begin
          cmd.setOvf = 1'b1;
          nextState  = stat.segLastReg ? ST_FIN : ST_DRAIN;
        end else begin
          cmd.wrAddrWord = 1'b1;
          nextState      = ST_LEN;
        end
      end
      ST_LEN: begin
        cmd.wrLenWord = 1'b1;
        if (stat.pieceEnd) nextState = stat.segLastReg ? ST_FIN : ST_GET;
        else               nextState = ST_ADDR;
      end
      ST_DRAIN: begin
        segReady = 1'b1;
        if (segValid && segLast) nextState = ST_FIN;
      end
      ST_FIN: begin
        // read-modify-write of the last length word with the end flag
        if (!stat.ovf && stat.haveEntries && !stat.altMode) cmd.wrMark = 1'b1;
        nextState = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sgt_datapath.sv
module sgt_datapath
  import sgt_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W = $clog2(2 * MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sgtCmd_t          cmd,
  input  logic             altIn,
  input  logic             splitIn,
  input  logic [31:0]      segAddr,
  input  logic [31:0]      segLen,
  input  logic             segLast,
  output sgtStat_t         stat,
  output logic             wrEn,
  output logic [IDX_W-1:0] wrIdx,
  output logic [31:0]      wrData,
  output logic [CNT_W-1:0] entryCount,
  output logic             overflow
);

  localparam logic [CNT_W:0] MAX_V = (CNT_W + 1)'(MAX_ENTRIES);

  logic [31:0]      curAddr, remLen, lastLenWord;
  logic [CNT_W-1:0] count;
  logic             altMode, splitEn, ovf, lastSeg;

  logic [16:0]      room;
  logic [31:0]      chunk, eff, lenWord;
  logic             fullSplit;
  logic [15:0]      quarter;
  logic [CNT_W:0]   nextCount, twice, idxLen, idxMark;

  // piece sizing at the 64 KB boundary
  always_comb begin
    room      = 17'h1_0000 - {1'b0, curAddr[15:0]};
    chunk     = (remLen < {15'd0, room}) ? remLen : {15'd0, room};
    fullSplit = splitEn && !altMode && (chunk == FULL_CHUNK);
    eff       = fullSplit ? HALF_CHUNK : chunk;
    quarter   = eff[17:2] - 16'd1;
    lenWord   = altMode ? {quarter, 16'h0000} : {16'h0000, eff[15:0]};
    nextCount = {1'b0, count} + {{(CNT_W - 1){1'b0}}, fullSplit, !fullSplit};
  end

  // table word indices
  always_comb begin
    twice   = {count, 1'b0};
    idxLen  = twice + (CNT_W + 1)'(1);
    idxMark = twice - (CNT_W + 1)'(1);
  end

  always_comb begin
    stat.segZero     = (segLen == 32'd0);
    stat.segLastReg  = lastSeg;
    stat.pieceEnd    = (remLen == eff);
    stat.wouldOvf    = (nextCount > MAX_V);
    stat.haveEntries = (count != '0);
    stat.altMode     = altMode;
    stat.ovf         = ovf;
  end

  always_comb begin
    wrEn   = cmd.wrAddrWord | cmd.wrLenWord | cmd.wrMark;
    wrIdx  = twice[IDX_W-1:0];
    wrData = curAddr;
    if (cmd.wrLenWord) begin
      wrIdx  = idxLen[IDX_W-1:0];
      wrData = lenWord;
    end else if (cmd.wrMark) begin
      wrIdx  = idxMark[IDX_W-1:0];
      wrData = lastLenWord | END_FLAG;
    end
  end

  assign entryCount = ovf ? '0 : count;
  assign overflow   = ovf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr     <= '0;
      remLen      <= '0;
      lastLenWord <= '0;
      count       <= '0;
      altMode     <= 1'b0;
      splitEn     <= 1'b0;
      ovf         <= 1'b0;
      lastSeg     <= 1'b0;
    end else begin
      if (cmd.init) begin
        altMode <= altIn;
        splitEn <= splitIn;
        count   <= '0;
        ovf     <= 1'b0;
      end
      if (cmd.loadSeg) begin
        curAddr <= segAddr;
        remLen  <= segLen;
        lastSeg <= segLast;
      end
      if (cmd.wrLenWord) begin
        count       <= count + CNT_W'(1);
        curAddr     <= curAddr + eff;
        remLen      <= remLen - eff;
        lastLenWord <= lenWord;
      end
      if (cmd.setOvf) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/sgt_builder.sv
module sgt_builder
  import sgt_pkg::*;
#(
  parameter int MAX_ENTRIES = 256
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                start,
  input  logic                                altLenMode,
  input  logic                                splitFullChunk,
  input  logic                                segValid,
  output logic                                segReady,
  input  logic [31:0]                         segAddr,
  input  logic [31:0]                         segLen,
  input  logic                                segLast,
  output logic                                wrEn,
  output logic [$clog2(2*MAX_ENTRIES)-1:0]    wrIdx,
  output logic [31:0]                         wrData,
  output logic                                done,
  output logic [$clog2(MAX_ENTRIES+1)-1:0]    entryCount,
  output logic                                overflow
);

  sgtCmd_t  cmd;
  sgtStat_t stat;

  sgt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .segValid (segValid),
    .segLast  (segLast),
    .stat     (stat),
    .cmd      (cmd),
    .segReady (segReady),
    .done     (done)
  );

  sgt_datapath #(.MAX_ENTRIES(MAX_ENTRIES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .altIn      (altLenMode),
    .splitIn    (splitFullChunk),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .segLast    (segLast),
    .stat       (stat),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .entryCount (entryCount),
    .overflow   (overflow)
  );

endmodule

// File: rtl/sgt_checker.sv
module sgt_checker #(
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             segReady,
  input logic             wrEn,
  input logic             done,
  input logic [CNT_W-1:0] entryCount,
  input logic             overflow
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ENTRIES);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(entryCount) && $stable(overflow)));

  // R8
  ovf_zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (entryCount == '0));

  // R12
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (entryCount <= MAX_C));

  // R3
  fetch_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    segReady |-> !wrEn);

endmodule

bind sgt_builder sgt_checker #(.MAX_ENTRIES(MAX_ENTRIES)) u_sgtChk (
  .clk        (clk),
  .rstN       (rstN),
  .segReady   (segReady),
  .wrEn       (wrEn),
  .done       (done),
  .entryCount (entryCount),
  .overflow   (overflow)
);

// File: tb/test_sgt_builder.sv
`timescale 1ns/1ps
module test_sgt_builder;

  localparam int MAXE  = 8;
  localparam int IDX_W = $clog2(2 * MAXE);
  localparam int CNT_W = $clog2(MAXE + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, altLenMode = 1'b0, splitFullChunk = 1'b0;
  logic segValid = 1'b0, segLast = 1'b0;
  logic [31:0] segAddr = '0, segLen = '0;
  logic segReady, wrEn, done, overflow;
  logic [IDX_W-1:0] wrIdx;
  logic [31:0] wrData;
  logic [CNT_W-1:0] entryCount;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  logic [31:0] mem [2*MAXE];
  logic [CNT_W-1:0] gotCount;
  logic gotOvf;

  always #2 clk = ~clk;

  sgt_builder #(.MAX_ENTRIES(MAXE)) i_sgt_builder (
    .clk(clk), .rstN(rstN), .start(start), .altLenMode(altLenMode),
    .splitFullChunk(splitFullChunk), .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segLen(segLen), .segLast(segLast), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .done(done), .entryCount(entryCount),
    .overflow(overflow)
  );

  // table memory model
  always @(posedge clk) if (wrEn) mem[wrIdx] <= wrData;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog (R10): actual no done, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] len;
    logic        alt;
    logic        split;
    logic [7:0]  cnt;
    logic [31:0] len0;
    logic [31:0] lastLen;
    logic [31:0] addr1;
  } vec_t;

  // single-segment vectors: expected count, first length word, last length word, second address
  localparam vec_t VECS [8] = '{
    '{32'h0000_1000, 32'h0000_0200, 1'b0, 1'b0, 8'd1, 32'h8000_0200, 32'h8000_0200, 32'h0},
    '{32'h0001_FF00, 32'h0000_0300, 1'b0, 1'b0, 8'd2, 32'h0000_0100, 32'h8000_0200, 32'h0002_0000},
    '{32'h0003_0000, 32'h0001_0000, 1'b0, 1'b1, 8'd2, 32'h0000_8000, 32'h8000_8000, 32'h0003_8000},
    '{32'h0003_0000, 32'h0001_0000, 1'b0, 1'b0, 8'd1, 32'h8000_0000, 32'h8000_0000, 32'h0},
    '{32'h0004_0000, 32'h0001_0000, 1'b1, 1'b1, 8'd1, 32'h3FFF_0000, 32'h3FFF_0000, 32'h0},
    '{32'h0005_F000, 32'h0000_2000, 1'b1, 1'b0, 8'd2, 32'h03FF_0000, 32'h03FF_0000, 32'h0006_0000},
    '{32'h0006_8000, 32'h0001_8000, 1'b0, 1'b1, 8'd3, 32'h0000_8000, 32'h8000_8000, 32'h0007_0000},
    '{32'h0000_7000, 32'h0000_0000, 1'b0, 1'b0, 8'd0, 32'h0,         32'h0,         32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 2 * MAXE; i++) mem[i] = 32'hDEAD_BEEF;
  endtask

  task automatic startBuild(input logic alt, input logic split);
    @(negedge clk);
    start = 1'b1; altLenMode = alt; splitFullChunk = split;
    @(negedge clk);
    start = 1'b0; altLenMode = 1'b0; splitFullChunk = 1'b0;
  endtask

  task automatic sendSeg(input logic [31:0] a, input logic [31:0] l, input logic last);
    @(negedge clk);
    segValid = 1'b1; segAddr = a; segLen = l; segLast = last;
    while (!segReady) @(negedge clk);
    @(negedge clk);
    segValid = 1'b0; segLast = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
    gotCount = entryCount;
    gotOvf = overflow;
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
    chk("R10 count held", {{(32-CNT_W){1'b0}}, entryCount}, {{(32-CNT_W){1'b0}}, gotCount});
  endtask

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 segReady", {31'd0, segReady}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 wrEn", {31'd0, wrEn}, 32'd0);
    chk("R1 entryCount", {{(32-CNT_W){1'b0}}, entryCount}, 32'd0);
    chk("R1 overflow", {31'd0, overflow}, 32'd0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      clearMem();
      startBuild(VECS[v].alt, VECS[v].split);
      sendSeg(VECS[v].addr, VECS[v].len, 1'b1);
      waitDone();
      chk("R2 R5 R9 count", {{(32-CNT_W){1'b0}}, gotCount}, {24'd0, VECS[v].cnt});
      chk("R8 no overflow", {31'd0, gotOvf}, 32'd0);
      if (VECS[v].cnt > 0) begin
        chk("R3 address word 0", mem[0], VECS[v].addr);
        chk("R4 R5 R6 first length word", mem[1], VECS[v].len0);
        chk("R7 last length word", mem[2*VECS[v].cnt-1], VECS[v].lastLen);
      end else begin
        chk("R9 no write", mem[0], 32'hDEAD_BEEF);
      end
      if (VECS[v].cnt > 1) chk("R2 R5 second address", mem[2], VECS[v].addr1);
    end

    // multi-segment, zero-length middle, start ignored mid-build
    clearMem();
    startBuild(1'b0, 1'b0);
    sendSeg(32'h0000_0100, 32'h80, 1'b0);
    startBuild(1'b1, 1'b1); // R11: must be ignored
    sendSeg(32'h0000_9000, 32'h0, 1'b0);
    sendSeg(32'h0000_9000, 32'h40, 1'b1);
    waitDone();
    chk("R9 zero segment skipped count", {{(32-CNT_W){1'b0}}, gotCount}, 32'd2);
    chk("R7 no marker on first", mem[1], 32'h0000_0080);
    chk("R11 normal mode kept", mem[3], 32'h8000_0040);
    chk("R3 second address word", mem[2], 32'h0000_9000);

    // exact fit
    clearMem();
    startBuild(1'b0, 1'b0);
    sendSeg(32'h0, 32'h0008_0000, 1'b1);
    waitDone();
    chk("R12 exact count", {{(32-CNT_W){1'b0}}, gotCount}, 32'd8);
    chk("R12 no overflow", {31'd0, gotOvf}, 32'd0);
    chk("R12 last address", mem[14], 32'h0007_0000);
    chk("R7 R12 last length", mem[15], 32'h8000_0000);

    // split pushes past the limit
    startBuild(1'b0, 1'b1);
    sendSeg(32'h0000_8000, 32'h0004_8000, 1'b1);
    waitDone();
    chk("R8 R5 split overflow flag", {31'd0, gotOvf}, 32'd1);
    chk("R8 split overflow count", {{(32-CNT_W){1'b0}}, gotCount}, 32'd0);

    // same request without split fits
    startBuild(1'b0, 1'b0);
    sendSeg(32'h0000_8000, 32'h0004_8000, 1'b1);
    waitDone();
    chk("R5 unsplit count", {{(32-CNT_W){1'b0}}, gotCount}, 32'd5);
    chk("R5 R8 unsplit overflow", {31'd0, gotOvf}, 32'd0);

    // overflow mid-request, then drain
    startBuild(1'b0, 1'b0);
    sendSeg(32'h0, 32'h0009_0000, 1'b0);
    sendSeg(32'h0000_0100, 32'h10, 1'b1);
    waitDone();
    chk("R8 drain overflow", {31'd0, gotOvf}, 32'd1);
    chk("R8 drain count", {{(32-CNT_W){1'b0}}, gotCount}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 overflow held", {31'd0, overflow}, 32'd1);
    chk("R10 count still zero", {{(32-CNT_W){1'b0}}, entryCount}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule